// File: doc/BRIEF.md
# Carry-Chained Integer ALU

This block is the purely combinational arithmetic and logic stage of a small controller-style core. In one pass it takes a first source register, a second operand and an operation code, and it returns a 32-bit result together with the next value of the core's carry flag. The second operand is either a second register value or an 8-bit immediate that is zero-extended to the full width. One select bit picks between them.

The six arithmetic operations are add, add with carry, subtract, subtract with carry, reverse subtract and reverse subtract with carry. For every one of them the carry flag is the bit just above the result width of a widened sum or difference. On subtraction that bit is the raw borrow: it reads 1 when the difference goes below zero. The remaining operations are:

- logical left and right shift;
- AND, OR, XOR and NOT;
- unsigned minimum and maximum;
- clearing or setting one selected bit.

A separate write-enable output tells the surrounding core whether to store the new carry value. The register file, the instruction decoder and the carry flag register itself all live outside this block.

Top module: `carry_alu`

## Requirements
- R1: The second operand equals the 8-bit immediate zero-extended to 32 bits when `imm_sel_i` is 1. When `imm_sel_i` is 0 it equals `rs2_i`, and in that case `imm_i` has no effect. When `imm_sel_i` is 1, `rs2_i` has no effect.
- R2: Opcode 0 (add) gives `rs1 + op2`. Opcode 1 (add with carry) gives `rs1 + op2 + carry_i`. For both, `carry_o` is bit 32 of the 33-bit zero-extended sum.
- R3: Opcode 2 (subtract) gives `rs1 - op2`. Opcode 3 (subtract with carry) gives `rs1 - op2 - carry_i`. For both, `carry_o` is bit 32 of the 33-bit zero-extended difference, so it is 1 exactly when a borrow occurs.
- R4: Opcode 4 (reverse subtract) gives `op2 - rs1`. Opcode 5 (reverse subtract with carry) gives `op2 - rs1 - carry_i`. For both, `carry_o` is the borrow bit, taken the same way as in R3.
- R5: Opcode 6 shifts `rs1` left and opcode 7 shifts it right; both shifts are logical and fill with zeros. The shift distance is `op2[4:0]`, and the higher bits of `op2` have no effect.
- R6: Opcode 8 gives AND, opcode 9 gives OR and opcode 10 gives XOR, each applied to `rs1` and `op2`. Opcode 11 gives `~rs1`, and the second operand has no effect on it.
- R7: Opcode 12 returns the smaller and opcode 13 returns the larger of `rs1` and `op2`, with both compared as unsigned values.
- R8: Opcode 14 clears and opcode 15 sets bit `op2[4:0]` of `rs1`. All other bits pass through unchanged.
- R9: `carry_we_o` is 1 for opcodes 0 to 5 and 0 for opcodes 6 to 15. Whenever `carry_we_o` is 0, `carry_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1_i | input | 32 | First source register value |
| rs2_i | input | 32 | Second source register value |
| imm_i | input | 8 | Immediate operand, zero-extended before use |
| imm_sel_i | input | 1 | 1 selects the immediate as second operand |
| op_i | input | 4 | Operation code (see requirements) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Operation result |
| carry_o | output | 1 | Next carry flag value |
| carry_we_o | output | 1 | Carry flag update enable |

## Verification
The two functions that can land in one evaluation are the operand selection and the carry-chained arithmetic. An immediate-driven subtract with carry must therefore produce a correct borrow from a zero-extended value. The hardest case has equal operands with carry-in set: the result wraps to all ones and the borrow comes from the carry-in alone. The bench applies this case directly, both with an immediate and with a register second operand that carries high bits the immediate path must not see. Each result and its carry are compared against a bench reference model built on widened arithmetic. Random vectors mix opcodes and select values, so every arithmetic operation is also exercised with shift-style operands wider than five bits.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDC  = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBC  = 4'd3,
        OP_RSUB  = 4'd4,
        OP_RSUBC = 4'd5,
        OP_SHL   = 4'd6,
        OP_SHR   = 4'd7,
        OP_AND   = 4'd8,
        OP_OR    = 4'd9,
        OP_XOR   = 4'd10,
        OP_NOT   = 4'd11,
        OP_MIN   = 4'd12,
        OP_MAX   = 4'd13,
        OP_BCLR  = 4'd14,
        OP_BSET  = 4'd15
    } alu_op_e;

    function automatic logic op_is_arith(input alu_op_e op);
        return (op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_RSUB, OP_RSUBC});
    endfunction

endpackage

// File: rtl/carry_alu_opsel.sv
module carry_alu_opsel #(
    parameter int W     = 32,
    parameter int IMM_W = 8
) (
    input  logic [W-1:0]     reg_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             sel_i,
    output logic [W-1:0]     op2_o
);
    localparam int PAD_W = W - IMM_W;

    logic [W-1:0] imm_ext_d;

    always_comb begin
        imm_ext_d = {{PAD_W{1'b0}}, imm_i};
        op2_o     = sel_i ? imm_ext_d : reg_i;
    end
endmodule

// File: rtl/carry_alu_arith.sv
module carry_alu_arith
    import carry_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    localparam int XW = W + 1;

    logic [XW-1:0] a_x_d;
    logic [XW-1:0] b_x_d;
    logic [XW-1:0] c_x_d;
    logic [XW-1:0] wide_d;

    always_comb begin
        a_x_d = {1'b0, a_i};
        b_x_d = {1'b0, b_i};
        c_x_d = {{W{1'b0}}, cin_i};
        unique case (op_i)
            OP_ADD:   wide_d = a_x_d + b_x_d;
            OP_ADDC:  wide_d = a_x_d + b_x_d + c_x_d;
            OP_SUB:   wide_d = a_x_d - b_x_d;
            OP_SUBC:  wide_d = a_x_d - b_x_d - c_x_d;
            OP_RSUB:  wide_d = b_x_d - a_x_d;
            OP_RSUBC: wide_d = b_x_d - a_x_d - c_x_d;
            default:  wide_d = '0;
        endcase
        res_o  = wide_d[W-1:0];
        cout_o = wide_d[W];
    end
endmodule

// File: rtl/carry_alu_logic.sv
module carry_alu_logic
    import carry_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] idx_d;
    logic [W-1:0]   bit_mask_d;

    assign idx_d = b_i[SHW-1:0];

    for (genvar g = 0; g < W; g++) begin : g_mask
        assign bit_mask_d[g] = (idx_d == SHW'(g));
    end

    always_comb begin
        unique case (op_i)
            OP_SHL:  res_o = a_i << idx_d;
            OP_SHR:  res_o = a_i >> idx_d;
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NOT:  res_o = ~a_i;
            OP_MIN:  res_o = (a_i < b_i) ? a_i : b_i;
            OP_MAX:  res_o = (a_i > b_i) ? a_i : b_i;
            OP_BCLR: res_o = a_i & ~bit_mask_d;
            OP_BSET: res_o = a_i | bit_mask_d;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/carry_alu.sv
module carry_alu
    import carry_alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 8
) (
    input  logic [31:0] rs1_i,
    input  logic [31:0] rs2_i,
    input  logic [7:0]  imm_i,
    input  logic        imm_sel_i,
    input  logic [3:0]  op_i,
    input  logic        carry_i,
    output logic [31:0] result_o,
    output logic        carry_o,
    output logic        carry_we_o
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         cout;
        logic         we;
    } alu_out_t;

    alu_op_e      op_d;
    logic [W-1:0] op2_d;
    logic [W-1:0] arith_res_d;
    logic         arith_cout_d;
    logic [W-1:0] logic_res_d;
    alu_out_t     out_d;

    assign op_d = alu_op_e'(op_i);

    carry_alu_opsel #(.W(W), .IMM_W(IMM_W)) u_opsel (
        .reg_i (rs2_i),
        .imm_i (imm_i),
        .sel_i (imm_sel_i),
        .op2_o (op2_d)
    );

    carry_alu_arith #(.W(W)) u_arith (
        .op_i   (op_d),
        .a_i    (rs1_i),
        .b_i    (op2_d),
        .cin_i  (carry_i),
        .res_o  (arith_res_d),
        .cout_o (arith_cout_d)
    );

    carry_alu_logic #(.W(W)) u_logic (
        .op_i  (op_d),
        .a_i   (rs1_i),
        .b_i   (op2_d),
        .res_o (logic_res_d)
    );

    always_comb begin
        out_d.we = op_is_arith(op_d);
        if (out_d.we) begin
            out_d.res  = arith_res_d;
            out_d.cout = arith_cout_d;
        end else begin
            out_d.res  = logic_res_d;
            out_d.cout = 1'b0;
        end
    end

    assign result_o   = out_d.res;
    assign carry_o    = out_d.cout;
    assign carry_we_o = out_d.we;
endmodule

// File: rtl/carry_alu_chk.sv
module carry_alu_chk (
    input logic [31:0] rs1_i,
    input logic [31:0] rs2_i,
    input logic [7:0]  imm_i,
    input logic        imm_sel_i,
    input logic [3:0]  op_i,
    input logic [31:0] result_o,
    input logic        carry_o,
    input logic        carry_we_o
);
    logic [31:0] op2_c;
    logic [4:0]  idx_c;

    always_comb begin
        op2_c = imm_sel_i ? {24'd0, imm_i} : rs2_i;
        idx_c = op2_c[4:0];
        if (!carry_we_o) begin
            AST_FLAG_QUIET: assert (carry_o == 1'b0); // R9
        end
        if (op_i == 4'd11) begin
            AST_NOT_INVERTS: assert (result_o == ~rs1_i); // R6
        end
        if (op_i == 4'd8) begin
            AST_AND_SUBSET: assert ((result_o & ~rs1_i) == 32'd0 && (result_o & ~op2_c) == 32'd0); // R6
        end
        if (op_i == 4'd12) begin
            AST_MIN_BOUND: assert (result_o <= rs1_i && result_o <= op2_c); // R7
        end
        if (op_i == 4'd13) begin
            AST_MAX_BOUND: assert (result_o >= rs1_i && result_o >= op2_c); // R7
        end
        if (op_i == 4'd15) begin
            AST_BIT_SET: assert (result_o[idx_c] == 1'b1); // R8
        end
        if (op_i == 4'd14) begin
            AST_BIT_CLEAR: assert (result_o[idx_c] == 1'b0); // R8
        end
    end
endmodule

bind carry_alu carry_alu_chk u_chk (
    .rs1_i      (rs1_i),
    .rs2_i      (rs2_i),
    .imm_i      (imm_i),
    .imm_sel_i  (imm_sel_i),
    .op_i       (op_i),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .carry_we_o (carry_we_o)
);

// File: tb/carry_alu_tb.sv
module carry_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rs1, rs2;
    logic [7:0]  imm;
    logic        isel;
    logic [3:0]  op;
    logic        cin;
    logic [31:0] res;
    logic        cout, cwe;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    carry_alu u_dut (
        .rs1_i(rs1), .rs2_i(rs2), .imm_i(imm), .imm_sel_i(isel),
        .op_i(op), .carry_i(cin), .result_o(res), .carry_o(cout), .carry_we_o(cwe)
    );

    function automatic string tag_of(input logic [3:0] o);
        if (o < 4'd2) return "R2";
        if (o < 4'd4) return "R3";
        if (o < 4'd6) return "R4";
        if (o < 4'd8) return "R5";
        if (o < 4'd12) return "R6";
        if (o < 4'd14) return "R7";
        return "R8";
    endfunction

    function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] r2,
                                          input logic [7:0] im, input logic s,
                                          input logic [3:0] o, input logic c);
        logic [31:0] b;
        logic [32:0] w;
        logic [31:0] r;
        logic        we;
        b  = s ? {24'd0, im} : r2;
        w  = 33'd0;
        r  = 32'd0;
        we = (o <= 4'd5);
        case (o)
            4'd0:  w = {1'b0, a} + {1'b0, b};
            4'd1:  w = {1'b0, a} + {1'b0, b} + {32'd0, c};
            4'd2:  w = {1'b0, a} - {1'b0, b};
            4'd3:  w = {1'b0, a} - {1'b0, b} - {32'd0, c};
            4'd4:  w = {1'b0, b} - {1'b0, a};
            4'd5:  w = {1'b0, b} - {1'b0, a} - {32'd0, c};
            4'd6:  r = a << b[4:0];
            4'd7:  r = a >> b[4:0];
            4'd8:  r = a & b;
            4'd9:  r = a | b;
            4'd10: r = a ^ b;
            4'd11: r = ~a;
            4'd12: r = (a < b) ? a : b;
            4'd13: r = (a > b) ? a : b;
            4'd14: begin r = a; r[b[4:0]] = 1'b0; end
            default: begin r = a; r[b[4:0]] = 1'b1; end
        endcase
        if (we) r = w[31:0];
        return {we, we & w[32], r};
    endfunction

    task automatic chk32(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] r2, input logic [7:0] im,
                         input logic s, input logic [3:0] o, input logic c, input string t);
        logic [33:0] e;
        @(posedge clk);
        rs1 = a; rs2 = r2; imm = im; isel = s; op = o; cin = c;
        @(negedge clk);
        e = model(a, r2, im, s, o, c);
        chk32(t, "result", res, e[31:0]);
        chk32(t, "carry", {31'd0, cout}, {31'd0, e[32]});
        chk32("R9", "carry_we", {31'd0, cwe}, {31'd0, e[33]});
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        rs1 = '0; rs2 = '0; imm = '0; isel = 1'b0; op = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk32("R2", "idle result", res, 32'd0);
        chk32("R9", "idle we", {31'd0, cwe}, 32'd1);
        // R1 immediate zero-extension, register ignored
        apply(32'h10, 32'hFFFF_0000, 8'hFF, 1'b1, 4'd0, 1'b0, "R1");
        apply(32'h10, 32'h0000_0003, 8'hFF, 1'b0, 4'd0, 1'b0, "R1");
        // R2 carry out of add
        apply(32'hFFFF_FFFF, 32'd1, 8'd0, 1'b0, 4'd0, 1'b0, "R2");
        apply(32'hFFFF_FFFF, 32'd0, 8'd0, 1'b0, 4'd1, 1'b1, "R2");
        // R3 borrow from carry-in alone, immediate and register paths
        apply(32'h5A, 32'hFFFF_FF00, 8'h5A, 1'b1, 4'd3, 1'b1, "R3");
        apply(32'h5A, 32'h0000_005A, 8'h00, 1'b0, 4'd3, 1'b1, "R3");
        apply(32'd3, 32'd5, 8'd0, 1'b0, 4'd2, 1'b0, "R3");
        apply(32'd5, 32'd3, 8'd0, 1'b0, 4'd2, 1'b0, "R3");
        // R4 reverse forms
        apply(32'd1, 32'd0, 8'd0, 1'b0, 4'd4, 1'b0, "R4");
        apply(32'd7, 32'd0, 8'd7, 1'b1, 4'd5, 1'b1, "R4");
        // R5 shift amount masked
        apply(32'h8000_0001, 32'h0000_0021, 8'd0, 1'b0, 4'd6, 1'b0, "R5");
        apply(32'h8000_0001, 32'd0, 8'hFF, 1'b1, 4'd7, 1'b0, "R5");
        // R6 NOT ignores second operand
        apply(32'h1234_5678, 32'hFFFF_FFFF, 8'hAA, 1'b0, 4'd11, 1'b1, "R6");
        // R7 unsigned compare
        apply(32'h8000_0000, 32'd1, 8'd0, 1'b0, 4'd12, 1'b0, "R7");
        apply(32'h8000_0000, 32'd1, 8'd0, 1'b0, 4'd13, 1'b0, "R7");
        // R8 bit index masked
        apply(32'hFFFF_FFFF, 32'h0000_003F, 8'd0, 1'b0, 4'd14, 1'b0, "R8");
        apply(32'h0, 32'd0, 8'h20, 1'b1, 4'd15, 1'b0, "R8");
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] o;
            o = 4'($urandom);
            apply($urandom, $urandom, 8'($urandom), 1'($urandom), o, 1'($urandom), tag_of(o));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule